// File: doc/BRIEF.md
# Performance Monitor Register Access Gate

This block stores the control and counter registers of a performance monitor and serves every move-to and move-from special-register access made to them. Each request is a single cycle with a valid flag, a write enable, an 8-bit register number, a privilege flag and 32-bit write data. A privileged request reaches any register with no check and no mask. A user-state request is checked against a two-bit permission field held in control register 0 (bits 19:18). The outcome of that check is one of three: the access is allowed with masked data, the access is refused with a facility-unavailable exception, or the access is refused with a hypervisor-emulation exception.

The registers are counters C1 to C6 and control registers K0, K1, K2 and KA. On an allowed user access, K0 shows only bits 31, 26 and 7, and K2 shows only one freeze bit per counter. A masked write changes only the visible bits and keeps all the others. When the permission field is 0b11, counters C5 and C6 are removed from user view. Read data and exception pulses are registered, so they appear one cycle after the request.

A small state machine records what the previous request did. Its states are ST_IDLE (no request), ST_DONE (the request was accepted, including a number that hits no register) and ST_TRAP (the request was refused). From any state, a cycle with no request moves to ST_IDLE, an accepted request moves to ST_DONE and a refused request moves to ST_TRAP. The exception outputs are driven only in ST_TRAP.

Top module: `pmg_gate`

## Requirements
- R1: A user read of K0 (0x38), K2 (0x3A), KA (0x3B) or counters 0x10..0x15 is refused only when the field K0[19:18] is 0b01. It then raises exc_fac with cause 2'b01.
- R2: A user write to those registers is allowed only when the field is 0b10 or 0b11. A field of 0b00 raises exc_hv with cause 2'b10, and a field of 0b01 raises exc_fac with cause 2'b01.
- R3: When the field is 0b11, a user read or write of C5 (0x14) or C6 (0x15) raises exc_fac with cause 2'b11. This check is made before the R1/R2 check. With any other field value, C5 and C6 follow R1/R2.
- R4: An allowed user read of K0 returns only bits 31, 26 and 7 of K0. All other bits read as zero.
- R5: An allowed user write of K0 or K2 takes the visible bits from the write data and keeps every other bit at its stored value. For K0 this includes the field bits.
- R6: In user state only the K2 bits set in the mask CTL2_UMASK (default 0x4210_8420) can be read or written. All other K2 bits read as zero.
- R7: User counter number 0x10+i and privileged number 0x20+i (i = 0..5) select the same physical counter Ci+1.
- R8: A refused access changes no register and returns zero read data. It raises exactly one of exc_fac and exc_hv for one cycle, with a nonzero cause.
- R9: A privileged access (number 0x20..0x25, K0 0x30, K1 0x31, K2 0x32, KA 0x33, or any user number) bypasses every check and every mask.
- R10: Read data and exceptions appear in the cycle after the request, and all outputs are zero when no request was made. After reset every register is zero. A number that hits no register (in user state this includes the privileged numbers) reads zero, raises no exception and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged state, 0 = user state |
| req_num | input | 8 | Special register number |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| exc_fac | output | 1 | Facility-unavailable exception pulse |
| exc_hv | output | 1 | Hypervisor-emulation exception pulse |
| exc_cause | output | 2 | Cause: 01 refused by field, 10 user write with field 00, 11 counter excluded |

## Verification
Some properties are checked on every cycle. Exceptions are mutually exclusive and match a nonzero cause. A trap always follows a user request and leaves the permission field untouched. The hypervisor exception only follows writes, and privileged or idle cycles stay silent. A user read of K0 never shows hidden bits. Other behaviour can be shown only by the bench's request sequences: the merge of masked writes into the stored value, the aliasing of user counter numbers onto privileged ones, the priority of the C5/C6 exclusion, and whether a refused write really left each register unchanged.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
    localparam int DW     = 32;
    localparam int RNW    = 8;
    localparam int NCNT   = 6;
    localparam int NEXCL  = 2;
    localparam int NREG   = NCNT + 4;
    localparam int IDXW   = $clog2(NREG);

    localparam int IX_K0  = NCNT;
    localparam int IX_K1  = NCNT + 1;
    localparam int IX_K2  = NCNT + 2;
    localparam int IX_KA  = NCNT + 3;

    localparam logic [RNW-1:0] USER_OFS      = 8'h10;
    localparam logic [RNW-1:0] PRIV_CNT_BASE = 8'h20;
    localparam logic [RNW-1:0] PRIV_K0       = 8'h30;
    localparam logic [RNW-1:0] PRIV_K1       = 8'h31;
    localparam logic [RNW-1:0] PRIV_K2       = 8'h32;
    localparam logic [RNW-1:0] PRIV_KA       = 8'h33;
    localparam logic [RNW-1:0] USER_K0       = 8'h38;
    localparam logic [RNW-1:0] USER_K2       = 8'h3A;
    localparam logic [RNW-1:0] USER_KA       = 8'h3B;

    localparam logic [DW-1:0]  K0_UMASK      = 32'h8400_0080;

    typedef enum logic [1:0] {
        CZ_NONE = 2'b00,
        CZ_FAC  = 2'b01,
        CZ_HV   = 2'b10,
        CZ_EXCL = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DONE = 2'b01,
        ST_TRAP = 2'b10
    } gate_st_e;

    typedef struct packed {
        logic            hit;
        logic            user_num;
        logic [IDXW-1:0] idx;
    } tgt_t;
endpackage

// File: rtl/pmg_decode.sv
module pmg_decode
    import pmg_pkg::*;
(
    input  logic [RNW-1:0] num,
    output tgt_t           tgt
);
    always_comb begin
        tgt = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (num == PRIV_CNT_BASE + RNW'(i)) begin
                tgt.hit = 1'b1;
                tgt.idx = IDXW'(i);
            end
            if (num == PRIV_CNT_BASE - USER_OFS + RNW'(i)) begin
                tgt.hit      = 1'b1;
                tgt.user_num = 1'b1;
                tgt.idx      = IDXW'(i);
            end
        end
        case (num)
            PRIV_K0: begin tgt.hit = 1'b1; tgt.idx = IDXW'(IX_K0); end
            PRIV_K1: begin tgt.hit = 1'b1; tgt.idx = IDXW'(IX_K1); end
            PRIV_K2: begin tgt.hit = 1'b1; tgt.idx = IDXW'(IX_K2); end
            PRIV_KA: begin tgt.hit = 1'b1; tgt.idx = IDXW'(IX_KA); end
            USER_K0: begin tgt.hit = 1'b1; tgt.user_num = 1'b1; tgt.idx = IDXW'(IX_K0); end
            USER_K2: begin tgt.hit = 1'b1; tgt.user_num = 1'b1; tgt.idx = IDXW'(IX_K2); end
            USER_KA: begin tgt.hit = 1'b1; tgt.user_num = 1'b1; tgt.idx = IDXW'(IX_KA); end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmg_permit.sv
module pmg_permit
    import pmg_pkg::*;
#(
    parameter logic [DW-1:0] CTL2_UMASK = 32'h4210_8420
) (
    input  logic          priv,
    input  logic          we,
    input  tgt_t          tgt,
    input  logic [1:0]    field,
    output logic          allow,
    output cause_e        cause,
    output logic [DW-1:0] mask
);
    logic excluded;

    assign excluded = (tgt.idx >= IDXW'(NCNT - NEXCL)) && (tgt.idx < IDXW'(NCNT));

    always_comb begin
        allow = 1'b1;
        cause = CZ_NONE;
        if (!priv && tgt.hit) begin
            if (excluded && field == 2'b11) begin
                allow = 1'b0;
                cause = CZ_EXCL;
            end else if (field == 2'b01) begin
                allow = 1'b0;
                cause = CZ_FAC;
            end else if (we && field == 2'b00) begin
                allow = 1'b0;
                cause = CZ_HV;
            end
        end
    end

    always_comb begin
        mask = '1;
        if (!priv) begin
            if (tgt.idx == IDXW'(IX_K0)) mask = K0_UMASK;
            else if (tgt.idx == IDXW'(IX_K2)) mask = CTL2_UMASK;
        end
    end
endmodule

// File: rtl/pmg_regfile.sv
module pmg_regfile
    import pmg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wmask,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rd_word,
    output logic [DW-1:0]   k0_word
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (idx == IDXW'(i)) regs[i] <= (regs[i] & ~wmask) | (wdata & wmask);
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDXW'(i)) rd_word = regs[i];
        end
    end

    assign k0_word = regs[IX_K0];
endmodule

// File: rtl/pmg_gate.sv
module pmg_gate
    import pmg_pkg::*;
#(
    parameter int            FIELD_LSB  = 18,
    parameter logic [31:0]   CTL2_UMASK = 32'h4210_8420
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic        req_priv,
    input  logic [7:0]  req_num,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        exc_fac,
    output logic        exc_hv,
    output logic [1:0]  exc_cause
);
    tgt_t          tgt_raw;
    tgt_t          tgt;
    logic          allow;
    cause_e        cause;
    logic [DW-1:0] mask;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] k0_word;
    logic [1:0]    ctl_field;
    logic          commit_we;

    gate_st_e      st_q, st_d;
    cause_e        cause_q;
    logic [DW-1:0] rdata_q;

    pmg_decode u_dec (
        .num (req_num),
        .tgt (tgt_raw)
    );

    always_comb begin
        tgt     = tgt_raw;
        tgt.hit = tgt_raw.hit && (req_priv || tgt_raw.user_num);
    end

    assign ctl_field = k0_word[FIELD_LSB +: 2];

    pmg_permit #(.CTL2_UMASK(CTL2_UMASK)) u_perm (
        .priv  (req_priv),
        .we    (req_we),
        .tgt   (tgt),
        .field (ctl_field),
        .allow (allow),
        .cause (cause),
        .mask  (mask)
    );

    assign commit_we = req_valid && req_we && allow && tgt.hit;

    pmg_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit_we),
        .idx     (tgt.idx),
        .wmask   (mask),
        .wdata   (req_wdata),
        .rd_word (rd_word),
        .k0_word (k0_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = !req_valid ? ST_IDLE : (allow ? ST_DONE : ST_TRAP);
            ST_DONE: st_d = !req_valid ? ST_IDLE : (allow ? ST_DONE : ST_TRAP);
            ST_TRAP: st_d = !req_valid ? ST_IDLE : (allow ? ST_DONE : ST_TRAP);
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cause_q <= CZ_NONE;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            cause_q <= req_valid ? cause : CZ_NONE;
            rdata_q <= (req_valid && !req_we && allow && tgt.hit) ? (rd_word & mask) : '0;
        end
    end

    always_comb begin
        rsp_rdata = rdata_q;
        exc_fac   = 1'b0;
        exc_hv    = 1'b0;
        exc_cause = CZ_NONE;
        unique case (st_q)
            ST_TRAP: begin
                exc_fac   = (cause_q != CZ_HV);
                exc_hv    = (cause_q == CZ_HV);
                exc_cause = cause_q;
            end
            ST_IDLE, ST_DONE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/pmg_gate_chk.sv
module pmg_gate_chk
    import pmg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_we,
    input logic        req_priv,
    input logic [7:0]  req_num,
    input logic [31:0] rsp_rdata,
    input logic        exc_fac,
    input logic        exc_hv,
    input logic [1:0]  exc_cause,
    input logic [1:0]  ctl_field
);
    a_r8_one_exception: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_fac, exc_hv}));

    a_r8_cause_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_fac || exc_hv) == (exc_cause != 2'b00));

    a_r8_zero_data_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_fac || exc_hv) |-> (rsp_rdata == '0));

    a_r8_field_kept_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_fac || exc_hv) |-> $stable(ctl_field));

    a_r8_trap_from_user: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_fac || exc_hv) |-> $past(req_valid && !req_priv));

    a_r2_hv_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        exc_hv |-> ($past(req_we) && exc_cause == 2'b10));

    a_r3_excl_is_fac: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_cause == 2'b11) |-> exc_fac);

    a_r9_priv_never_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv) |=> !(exc_fac || exc_hv));

    a_r4_k0_hidden_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && !req_we && req_num == USER_K0) |=> ((rsp_rdata & ~K0_UMASK) == '0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (rsp_rdata == '0 && !exc_fac && !exc_hv));
endmodule

bind pmg_gate pmg_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_priv  (req_priv),
    .req_num   (req_num),
    .rsp_rdata (rsp_rdata),
    .exc_fac   (exc_fac),
    .exc_hv    (exc_hv),
    .exc_cause (exc_cause),
    .ctl_field (ctl_field)
);

// File: tb/pmg_gate_tb.sv
`timescale 1ns/1ps
module pmg_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic        req_priv = 1'b0;
    logic [7:0]  req_num = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        exc_fac;
    logic        exc_hv;
    logic [1:0]  exc_cause;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_reg [10];

    always #2.5 clk = ~clk;

    pmg_gate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_priv  (req_priv),
        .req_num   (req_num),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .exc_fac   (exc_fac),
        .exc_hv    (exc_hv),
        .exc_cause (exc_cause)
    );

    task automatic model(input bit priv, input bit we, input logic [7:0] num,
                         input logic [31:0] wd, output logic [31:0] er, output logic [1:0] ec);
        int idx = -1;
        logic [1:0]  fld;
        logic [31:0] msk;
        for (int i = 0; i < 6; i++) begin
            if (priv && num == 8'(8'h20 + i)) idx = i;
            if (num == 8'(8'h10 + i)) idx = i;
        end
        case (num)
            8'h30: if (priv) idx = 6;
            8'h31: if (priv) idx = 7;
            8'h32: if (priv) idx = 8;
            8'h33: if (priv) idx = 9;
            8'h38: idx = 6;
            8'h3A: idx = 8;
            8'h3B: idx = 9;
            default: ;
        endcase
        fld = m_reg[6][19:18];
        ec  = 2'b00;
        er  = '0;
        if (idx < 0) return;
        if (!priv) begin
            if ((idx == 4 || idx == 5) && fld == 2'b11) ec = 2'b11;
            else if (fld == 2'b01) ec = 2'b01;
            else if (we && fld == 2'b00) ec = 2'b10;
        end
        if (ec != 2'b00) return;
        msk = '1;
        if (!priv && idx == 6) msk = 32'h8400_0080;
        if (!priv && idx == 8) msk = 32'h4210_8420;
        if (we) m_reg[idx] = (m_reg[idx] & ~msk) | (wd & msk);
        else    er = m_reg[idx] & msk;
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic [1:0] ec);
        logic ef, eh;
        ef = (ec == 2'b01) || (ec == 2'b11);
        eh = (ec == 2'b10);
        tests++;
        if (rsp_rdata !== er || exc_fac !== ef || exc_hv !== eh || exc_cause !== ec) begin
            fails++;
            $display("FAIL %s: rdata=%h fac=%b hv=%b cause=%b expected rdata=%h fac=%b hv=%b cause=%b",
                     tag, rsp_rdata, exc_fac, exc_hv, exc_cause, er, ef, eh, ec);
        end
    endtask

    task automatic do_req(input bit priv, input bit we, input logic [7:0] num,
                          input logic [31:0] wd, input string tag);
        logic [31:0] er;
        logic [1:0]  ec;
        model(priv, we, num, wd, er, ec);
        req_valid = 1'b1;
        req_priv  = priv;
        req_we    = we;
        req_num   = num;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, er, ec);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] nums [19];
        nums = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h20, 8'h21, 8'h22, 8'h23,
                 8'h24, 8'h25, 8'h30, 8'h31, 8'h32, 8'h33, 8'h38, 8'h3A, 8'h3B};
        for (int i = 0; i < 10; i++) m_reg[i] = '0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset outputs", '0, 2'b00);
        do_req(1, 0, 8'h30, '0, "R10 reset K0 zero");
        do_req(1, 0, 8'h25, '0, "R10 reset C6 zero");

        // field 00
        do_req(1, 1, 8'h30, 32'hFFF3_FFFF, "R9 priv write K0");
        do_req(1, 0, 8'h30, '0, "R9 priv read K0 unmasked");
        do_req(0, 0, 8'h38, '0, "R4 user read K0 masked");
        do_req(0, 1, 8'h38, 32'h0, "R2 user write field 00 hv");
        do_req(1, 0, 8'h30, '0, "R8 K0 unchanged after refused write");
        do_req(0, 1, 8'h14, 32'h77, "R3 field 00 C5 follows group check");
        do_req(0, 0, 8'h13, '0, "R1 user read field 00 allowed");

        // field 01
        do_req(1, 1, 8'h30, 32'h0004_0000, "R9 priv sets field 01");
        do_req(0, 0, 8'h3A, '0, "R1 user read field 01 refused");
        do_req(0, 1, 8'h10, 32'h99, "R2 user write field 01 fac");
        do_req(0, 0, 8'h15, '0, "R3 field 01 C6 follows group check");
        do_req(1, 0, 8'h32, '0, "R9 priv read ignores field");
        do_req(1, 0, 8'h20, '0, "R8 C1 unchanged after refused write");

        // field 10
        do_req(1, 1, 8'h30, 32'h0008_0000, "R9 priv sets field 10");
        do_req(0, 1, 8'h38, 32'hFFFF_FFFF, "R5 user write K0 merge");
        do_req(1, 0, 8'h30, '0, "R5 K0 merged value");
        do_req(1, 1, 8'h32, 32'hAAAA_AAAA, "R9 priv write K2");
        do_req(0, 1, 8'h3A, 32'hFFFF_FFFF, "R6 user write K2");
        do_req(1, 0, 8'h32, '0, "R6 K2 merged value");
        do_req(0, 0, 8'h3A, '0, "R6 user read K2 masked");
        do_req(0, 1, 8'h10, 32'h0000_1234, "R7 user write C1");
        do_req(1, 0, 8'h20, '0, "R7 priv read C1 alias");
        do_req(1, 1, 8'h25, 32'h0000_0055, "R7 priv write C6");
        do_req(0, 0, 8'h15, '0, "R7 user read C6 alias");

        // field 11
        do_req(1, 1, 8'h30, 32'h000C_0000, "R9 priv sets field 11");
        do_req(0, 1, 8'h14, 32'hDEAD, "R3 user write C5 excluded");
        do_req(0, 0, 8'h15, '0, "R3 user read C6 excluded");
        do_req(0, 0, 8'h13, '0, "R3 C4 still visible");
        do_req(1, 0, 8'h24, '0, "R8 C5 unchanged after exclusion");

        // unmapped
        do_req(0, 0, 8'h7F, '0, "R10 unknown user read");
        do_req(1, 1, 8'h7F, 32'hFFFF_FFFF, "R10 unknown priv write");
        do_req(0, 1, 8'h31, 32'hFFFF_FFFF, "R10 user write priv number");
        do_req(1, 0, 8'h31, '0, "R10 K1 untouched");

        for (int n = 0; n < 600; n++) begin
            bit          p, w;
            logic [7:0]  num;
            logic [31:0] d;
            p   = ($urandom_range(0, 2) == 0);
            w   = $urandom_range(0, 1) == 1;
            num = nums[$urandom_range(0, 18)];
            d   = $urandom();
            if ($urandom_range(0, 5) == 0) begin
                p = 1; w = 1; num = 8'h30;
            end
            do_req(p, w, num, d, "R8 random mix");
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R10 idle cycle", '0, 2'b00);
            end
        end
        for (int i = 0; i < 6; i++) do_req(1, 0, 8'(8'h20 + i), '0, "R7 final counter state");
        do_req(1, 0, 8'h30, '0, "R5 final K0 state");
        do_req(1, 0, 8'h32, '0, "R6 final K2 state");
        do_req(1, 0, 8'h33, '0, "R9 final KA state");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule